// File: doc/BRIEF.md
# Serial Transceiver Register Bank

This block is the software-visible control and status store of a serial transceiver. It decodes a 32-bit word bus and holds the configuration words that the shifting and baud logic read: three control words, a baud divisor, a guard/prescaler word and a receiver-timeout word. It also holds a status word, a receive data holding register and a transmit data holding register. Two further addresses perform actions and store nothing: a request port and a flag-clear port.

The serial datapath runs beside the bank. It uses single-cycle strobes to load received characters and to raise the transmit-empty, transmission-complete and idle flags. The bank sets the receive-not-empty and overrun flags itself. Software clears flags by writing ones to the flag-clear port, and it drains received characters by reading the receive data register. A single interrupt line combines four status flags, each gated by an enable bit in control word 1.

Top module: `sercom_regbank`

## Requirements
- R1: After reset the status word reads 0x020000C0, with transmit-empty (bit 7) and transmission-complete (bit 6) set. Every other register reads zero and the interrupt output is low.
- R2: Offsets 0x00, 0x04, 0x08, 0x10 and 0x14 (control 1/2/3, guard/prescaler, receiver timeout) store and return all 32 bits. The baud divisor at 0x0C returns only its low 16 bits. The transmit data register at 0x28 returns only its low 9 bits.
- R3: Read data is registered. `bus_rdata` takes the addressed value at the clock edge that samples `bus_rd`, and it holds that value until the next read.
- R4: A write to the flag-clear port at 0x20 clears every status bit whose write-data bit is 1, and leaves the other bits unchanged. A read of 0x20 returns zero.
- R5: The request port at 0x18 reads zero and a write to it has no effect. Writes to the status word at 0x1C and to the receive data register at 0x24 are ignored.
- R6: A read of 0x24 returns the low 9 bits of the receive data and clears receive-not-empty (bit 5) from the next cycle. If a receive strobe arrives in the same cycle as the read, the flag stays set.
- R7: A receive strobe loads the 9-bit receive input into the receive data register and sets receive-not-empty. If the flag was already set, and the receive data register is not being read in that cycle, the strobe also sets overrun (bit 3).
- R8: A write to 0x28 clears transmit-empty (bit 7) and transmission-complete (bit 6). The datapath strobes set bit 7, bit 6 and idle (bit 4). A strobe in the same cycle as a clearing write wins.
- R9: `irq` is high exactly when any of the following pairs are both set: control 1 bit 7 with status bit 7, bit 6 with bit 6, bit 5 with bit 5, or bit 4 with bit 4.
- R10: An access to an offset that is unlisted, or not aligned to 4 bytes, reads zero and changes no state. It raises `bus_err` for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Byte address within the 1 KiB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an unmapped or misaligned access |
| dp_rx_vld | input | 1 | Received character strobe |
| dp_rx_data | input | 9 | Received character |
| dp_txe_set | input | 1 | Set transmit-empty |
| dp_tc_set | input | 1 | Set transmission-complete |
| dp_idle_set | input | 1 | Set idle |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with its default parameters: a 10-bit address, 32-bit words, 9-bit characters and a 16-bit divisor. The 10-bit address brings the last word of the window (0x3FC), the first word past the map (0x2C) and misaligned addresses that alias mapped words within reach, so the error path can be shown to have no side effect. With 9-bit characters, the bench can confirm that the transmit data register truncates a wide write, and that received characters at the top of the range survive. With a 16-bit divisor, the bench can confirm that the upper half of a divisor write is dropped.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  localparam int NREG       = 11;
  localparam int NCFG       = 6;
  localparam int IDX_CTL1   = 0;
  localparam int IDX_CTL2   = 1;
  localparam int IDX_CTL3   = 2;
  localparam int IDX_BAUD   = 3;
  localparam int IDX_GUARD  = 4;
  localparam int IDX_TMO    = 5;
  localparam int IDX_REQ    = 6;
  localparam int IDX_STATUS = 7;
  localparam int IDX_CLR    = 8;
  localparam int IDX_RXD    = 9;
  localparam int IDX_TXD    = 10;

  localparam int B_TXE  = 7;
  localparam int B_TC   = 6;
  localparam int B_RXNE = 5;
  localparam int B_IDLE = 4;
  localparam int B_ORE  = 3;

  localparam logic [31:0] STATUS_RST = 32'h0200_00C0;
endpackage

// File: rtl/sercom_decode.sv
module sercom_decode #(
  parameter int ADDR_W = 10,
  parameter int NREG   = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc,
  output logic [NREG-1:0]   sel,
  output logic              hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = acc && aligned && (word == WORD_W'(i));
  end

  assign hit = |sel;
endmodule

// File: rtl/sercom_flags.sv
module sercom_flags
  import sercom_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic              rxd_rd,
  input  logic              txd_wr,
  input  logic              rx_vld,
  input  logic              txe_set,
  input  logic              tc_set,
  input  logic              idle_set,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] status_nxt;
  logic              status_en;

  assign status_en = clr_wr | rxd_rd | txd_wr | rx_vld | txe_set | tc_set | idle_set;

  always_comb begin
    status_nxt = status_q;
    if (clr_wr) status_nxt = status_nxt & ~clr_mask;
    if (rxd_rd) status_nxt[B_RXNE] = 1'b0;
    if (txd_wr) begin
      status_nxt[B_TXE] = 1'b0;
      status_nxt[B_TC]  = 1'b0;
    end
    if (rx_vld) begin
      if (status_q[B_RXNE] && !rxd_rd) status_nxt[B_ORE] = 1'b1;
      status_nxt[B_RXNE] = 1'b1;
    end
    if (txe_set)  status_nxt[B_TXE]  = 1'b1;
    if (tc_set)   status_nxt[B_TC]   = 1'b1;
    if (idle_set) status_nxt[B_IDLE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= DATA_W'(STATUS_RST);
    else if (status_en) status_q <= status_nxt;
  end

  assign status = status_q;

  AST_RXNE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && !rx_vld) |=> !status_q[B_RXNE]); // R6
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && status_q[B_RXNE] && !rxd_rd) |=> status_q[B_ORE]); // R7
  AST_RX_SETS_RXNE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> status_q[B_RXNE]); // R7
  AST_TXE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && !txe_set) |=> !status_q[B_TXE]); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !rx_vld && !txe_set && !tc_set && !idle_set)
      |=> ((status_q & $past(clr_mask)) == '0)); // R4
endmodule

// File: rtl/sercom_regbank.sv
module sercom_regbank
  import sercom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CHR_W  = 9,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              dp_rx_vld,
  input  logic [CHR_W-1:0]  dp_rx_data,
  input  logic              dp_txe_set,
  input  logic              dp_tc_set,
  input  logic              dp_idle_set,
  output logic              irq
);
  logic [NREG-1:0]   sel;
  logic              hit;
  logic              acc;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] cfg_rd [NCFG];
  logic [CHR_W-1:0]  rxd_q;
  logic [CHR_W-1:0]  txd_q;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              rxd_rd;
  logic              txd_wr;
  logic              clr_wr;

  assign acc = bus_rd | bus_wr;

  sercom_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_decode (
    .addr (bus_addr),
    .acc  (acc),
    .sel  (sel),
    .hit  (hit)
  );

  assign rxd_rd = bus_rd & sel[IDX_RXD];
  assign txd_wr = bus_wr & sel[IDX_TXD];
  assign clr_wr = bus_wr & sel[IDX_CLR];

  sercom_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (clr_wr),
    .clr_mask (bus_wdata),
    .rxd_rd   (rxd_rd),
    .txd_wr   (txd_wr),
    .rx_vld   (dp_rx_vld),
    .txe_set  (dp_txe_set),
    .tc_set   (dp_tc_set),
    .idle_set (dp_idle_set),
    .status   (status)
  );

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    logic cfg_we;
    assign cfg_we = bus_wr & sel[i];
    if (i == IDX_BAUD) begin : g_narrow
      logic [BAUD_W-1:0] cfg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= bus_wdata[BAUD_W-1:0];
      end
      assign cfg_rd[i] = DATA_W'(cfg_q);
    end else begin : g_full
      logic [DATA_W-1:0] cfg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= bus_wdata;
      end
      assign cfg_rd[i] = cfg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rxd_q <= '0;
    else if (dp_rx_vld) rxd_q <= dp_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      txd_q <= '0;
    else if (txd_wr) txd_q <= bus_wdata[CHR_W-1:0];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCFG; i++) begin
      if (sel[i]) rd_val = rd_val | cfg_rd[i];
    end
    if (sel[IDX_STATUS]) rd_val = rd_val | status;
    if (sel[IDX_RXD])    rd_val = rd_val | DATA_W'(rxd_q);
    if (sel[IDX_TXD])    rd_val = rd_val | DATA_W'(txd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= acc & ~hit;
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  assign irq = |(cfg_rd[IDX_CTL1][B_TXE:B_IDLE] & status[B_TXE:B_IDLE]);

  AST_RXD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rx_vld |=> (rxd_q == $past(dp_rx_data))); // R7
  AST_TXD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    txd_wr |=> (txd_q == $past(bus_wdata[CHR_W-1:0]))); // R2
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit) |=> bus_err); // R10
  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc || hit) |=> !bus_err); // R10
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel[IDX_STATUS] && !dp_rx_vld && !dp_txe_set && !dp_tc_set && !dp_idle_set)
      |=> $stable(status)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R3
endmodule

// File: tb/sercom_regbank_bench.sv
module sercom_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        dp_rx_vld;
  logic [8:0]  dp_rx_data;
  logic        dp_txe_set;
  logic        dp_tc_set;
  logic        dp_idle_set;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] rv;
  logic        ev;

  always #5 clk = ~clk;

  sercom_regbank u_sercom_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .dp_rx_vld(dp_rx_vld), .dp_rx_data(dp_rx_data),
    .dp_txe_set(dp_txe_set), .dp_tc_set(dp_tc_set),
    .dp_idle_set(dp_idle_set), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    ev = bus_err;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    ev = bus_err;
  endtask

  task automatic strobe(input logic rx, input logic [8:0] rxd,
                        input logic txe, input logic tc, input logic idle);
    @(negedge clk);
    dp_rx_vld = rx; dp_rx_data = rxd; dp_txe_set = txe; dp_tc_set = tc; dp_idle_set = idle;
    @(negedge clk);
    dp_rx_vld = 0; dp_txe_set = 0; dp_tc_set = 0; dp_idle_set = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i <= 10; i++) begin
      rd(10'(i * 4), rv);
      chk("R1 reset value", rv, (i == 7) ? 32'h0200_00C0 : 32'h0);
    end
  endtask

  task automatic t_config();
    wr(10'h04, 32'hA5A5_5A5A); rd(10'h04, rv); chk("R2 ctl2", rv, 32'hA5A5_5A5A);
    wr(10'h08, 32'h1234_5678); rd(10'h08, rv); chk("R2 ctl3", rv, 32'h1234_5678);
    wr(10'h10, 32'hDEAD_BEEF); rd(10'h10, rv); chk("R2 guard", rv, 32'hDEAD_BEEF);
    wr(10'h14, 32'hFFFF_FFFF); rd(10'h14, rv); chk("R2 timeout", rv, 32'hFFFF_FFFF);
    wr(10'h0C, 32'hFFFF_1234); rd(10'h0C, rv); chk("R2 baud low 16", rv, 32'h0000_1234);
    wr(10'h28, 32'hFFFF_FFFF); rd(10'h28, rv); chk("R2 txd low 9", rv, 32'h0000_01FF);
  endtask

  task automatic t_rd_timing();
    rd(10'h04, rv);
    @(negedge clk);
    bus_addr = 10'h10; bus_rd = 1'b1;
    #1 chk("R3 rdata before edge", bus_rdata, 32'hA5A5_5A5A);
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R3 rdata after edge", bus_rdata, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R3 rdata holds", bus_rdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_flag_clear();
    wr(10'h20, 32'hFFFF_FFFF);
    strobe(0, 0, 1, 1, 0);
    rd(10'h1C, rv); chk("R4 setup", rv, 32'h0000_00C0);
    wr(10'h20, 32'h0000_0040); rd(10'h1C, rv); chk("R4 partial clear", rv, 32'h0000_0080);
    rd(10'h20, rv); chk("R4 clear port reads zero", rv, 32'h0);
    wr(10'h20, 32'hFFFF_FFFF); rd(10'h1C, rv); chk("R4 full clear", rv, 32'h0);
  endtask

  task automatic t_readonly();
    wr(10'h18, 32'hFFFF_FFFF); rd(10'h18, rv); chk("R5 request reads zero", rv, 32'h0);
    rd(10'h1C, rv); chk("R5 request no effect on status", rv, 32'h0);
    wr(10'h1C, 32'hFFFF_FFFF); rd(10'h1C, rv); chk("R5 status write ignored", rv, 32'h0);
    wr(10'h24, 32'h0000_01FF); rd(10'h24, rv); chk("R5 rxd write ignored", rv, 32'h0);
  endtask

  task automatic t_rx();
    strobe(1, 9'h155, 0, 0, 0);
    rd(10'h1C, rv); chk("R7 rxne set", rv, 32'h20);
    rd(10'h24, rv); chk("R6 rxd value", rv, 32'h155);
    rd(10'h1C, rv); chk("R6 rxne cleared by read", rv, 32'h0);
    strobe(1, 9'h0AA, 0, 0, 0);
    strobe(1, 9'h101, 0, 0, 0);
    rd(10'h1C, rv); chk("R7 overrun", rv, 32'h28);
    rd(10'h24, rv); chk("R7 newest data kept", rv, 32'h101);
    wr(10'h20, 32'h8); rd(10'h1C, rv); chk("R7 overrun cleared, rxne off", rv, 32'h0);
    strobe(1, 9'h011, 0, 0, 0);
    @(negedge clk);
    bus_addr = 10'h24; bus_rd = 1'b1; dp_rx_vld = 1'b1; dp_rx_data = 9'h022;
    @(negedge clk);
    bus_rd = 1'b0; dp_rx_vld = 1'b0;
    chk("R6 read returns old data", bus_rdata, 32'h011);
    rd(10'h1C, rv); chk("R6 strobe wins over read, no overrun", rv, 32'h20);
    rd(10'h24, rv); chk("R7 same-cycle data loaded", rv, 32'h022);
  endtask

  task automatic t_tx();
    wr(10'h20, 32'hFFFF_FFFF);
    strobe(0, 0, 1, 0, 0); rd(10'h1C, rv); chk("R8 txe strobe", rv, 32'h80);
    strobe(0, 0, 0, 1, 0); rd(10'h1C, rv); chk("R8 tc strobe", rv, 32'hC0);
    strobe(0, 0, 0, 0, 1); rd(10'h1C, rv); chk("R8 idle strobe", rv, 32'hD0);
    wr(10'h28, 32'h41); rd(10'h1C, rv); chk("R8 txd write clears", rv, 32'h10);
    @(negedge clk);
    bus_addr = 10'h28; bus_wdata = 32'h42; bus_wr = 1'b1; dp_txe_set = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; dp_txe_set = 1'b0;
    rd(10'h1C, rv); chk("R8 strobe wins over write", rv, 32'h90);
  endtask

  task automatic t_irq();
    wr(10'h20, 32'hFFFF_FFFF);
    wr(10'h00, 32'hF0);
    chk("R9 no flags", {31'b0, irq}, 32'h0);
    strobe(0, 0, 0, 0, 1);
    chk("R9 idle", {31'b0, irq}, 32'h1);
    wr(10'h20, 32'h10);
    chk("R9 idle cleared", {31'b0, irq}, 32'h0);
    wr(10'h00, 32'h80);
    strobe(0, 0, 1, 0, 0);
    chk("R9 txe enabled", {31'b0, irq}, 32'h1);
    wr(10'h00, 32'h70);
    chk("R9 txe masked", {31'b0, irq}, 32'h0);
    strobe(1, 9'h1FF, 0, 0, 0);
    chk("R9 rxne enabled", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_bad();
    rd(10'h2C, rv); chk("R10 past map reads zero", rv, 32'h0);
    chk("R10 err pulse", {31'b0, ev}, 32'h1);
    @(negedge clk); chk("R10 err one cycle", {31'b0, bus_err}, 32'h0);
    rd(10'h3FC, rv); chk("R10 top of window", rv, 32'h0);
    chk("R10 err top", {31'b0, ev}, 32'h1);
    rd(10'h05, rv); chk("R10 misaligned read", rv, 32'h0);
    wr(10'h06, 32'hFFFF_FFFF); chk("R10 err misaligned write", {31'b0, ev}, 32'h1);
    rd(10'h04, rv); chk("R10 misaligned write no effect", rv, 32'hA5A5_5A5A);
    chk("R10 no err on valid access", {31'b0, ev}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
    dp_rx_vld = 0; dp_rx_data = '0; dp_txe_set = 0; dp_tc_set = 0; dp_idle_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_rd_timing();
    t_flag_clear();
    t_readonly();
    t_rx();
    t_tx();
    t_irq();
    t_bad();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule